// File: doc/BRIEF.md
# Multi-Context Transmit Command Scheduler

The scheduler sits between many virtual transmit interfaces and one shared transmit engine. Each interface owns a copy of the register window, and the scheduler picks the interface index out of the command address. Posted commands, each a length plus a "more pieces follow" flag, enter one queue. The engine takes them from the head strictly in order of acceptance, and only when the outgoing data FIFO has room for the whole piece.

A packet may be split into several pieces. Once a piece with the "more" flag is accepted, the scheduler locks onto that interface. Commands from every other interface are held off with ready low until the locked interface posts its final piece. Requesters therefore never need a software lock, and the engine never sees pieces of two packets interleaved.

A combinational read port returns a done word for any interface. The word carries a busy flag, a complete flag, FIFO full and low-watermark flags, and the copy length gathered so far for that interface's current packet. A counter tracks data FIFO occupancy: it grows by each issued length and shrinks by the drain count the engine reports.

Top module: `txsched_top`

## Requirements
- R1: The interface index is address bits [15:8] (shift 8, 8-bit mask) for both `cmd_addr` and `rd_addr`; all other address bits have no effect.
- R2: While `cfg_word[1]` is 0, `cmd_ready` is 0 and no command enters the queue; other `cfg_word` bits have no effect.
- R3: Issued commands appear on `issue_*` in acceptance order, each exactly once; a shown command stays stable until `issue_ready` takes it.
- R4: After a piece with `cmd_more`=1 from interface X is accepted, commands from any other interface see `cmd_ready`=0 until a piece from X with `cmd_more`=0 is accepted; commands from X are still accepted.
- R5: With `QDEPTH` commands queued, `cmd_ready` is 0; a refused command is never queued and never lost from the queue.
- R6: `issue_valid` is 1 only when the queue is non-empty and the head length does not exceed `FIFO_DEPTH` minus occupancy.
- R7: Occupancy rises by the issued length and falls by `drain_cnt`, clamped to the occupancy before the edge; done bit 29 is 1 when occupancy equals `FIFO_DEPTH`, and bit 28 is 1 when occupancy is below `low_thresh`.
- R8: Done bit 31 is 1 while the read interface has accepted but not yet issued commands; bits 27:20 read 0.
- R9: Done bits 19:0 hold the sum, modulo 2^20, of the issued lengths of the interface's current packet, restarting after a final piece; bit 30 is 1 when the last issued piece of that interface had "more" clear.
- R10: After reset the queue is empty, no lock is held, occupancy is 0, and every done word has all bits 0 except bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word; bit 1 enables command acceptance |
| cmd_valid | input | 1 | Command posted |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_addr | input | ADDR_W | Register address of the posting interface |
| cmd_len | input | 20 | Piece length in FIFO units |
| cmd_more | input | 1 | More pieces of this packet follow |
| issue_valid | output | 1 | Head command offered to the engine |
| issue_ready | input | 1 | Engine takes the offered command |
| issue_ctx | output | 8 | Interface index of the offered command |
| issue_len | output | 20 | Length of the offered command |
| issue_more | output | 1 | "More" flag of the offered command |
| drain_cnt | input | OCC_W | Units leaving the data FIFO this cycle |
| low_thresh | input | OCC_W | Low-watermark threshold |
| rd_addr | input | ADDR_W | Address selecting the done word to read |
| done_word | output | 32 | Done word of the selected interface |

## Verification
A wrong queue or lock state shows at the ports within one clock. It appears as a `cmd_ready` that differs from the expected value, or as an issued interface, length or flag that breaks acceptance order. A wrong occupancy appears in the next cycle as a full or low flag that is off, or as `issue_valid` that is held back or let through when it should not be. Per-interface bookkeeping errors appear as soon as that interface's done word is read: a busy bit that stays set, or a copy length that fails to restart after a final piece. The bench therefore compares every output against a behavioural model on every cycle, reading a done word that changes from cycle to cycle.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
   localparam int CTX_SHIFT = 8;
   localparam int CTX_W     = 8;
   localparam int NUM_CTX   = 1 << CTX_W;
   localparam int LEN_W     = 20;

   localparam int DW_BUSY   = 31;
   localparam int DW_DONE   = 30;
   localparam int DW_FULL   = 29;
   localparam int DW_LOW    = 28;
   localparam int CFG_TXEN  = 1;

   typedef struct packed {
      logic [CTX_W-1:0] ctx;
      logic [LEN_W-1:0] len;
      logic             more;
   } txcmd_t;
endpackage

// File: rtl/txsched_gate.sv
module txsched_gate
   import txsched_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             q_full,
   input  logic             cmd_valid,
   input  logic [CTX_W-1:0] cmd_ctx,
   input  logic             cmd_more,
   output logic             cmd_ready,
   output logic             accept,
   output logic             lock_on,
   output logic [CTX_W-1:0] lock_ctx
);
   logic lock_hit;

   assign lock_hit  = !lock_on || (cmd_ctx == lock_ctx);
   assign cmd_ready = tx_en && !q_full && lock_hit;
   assign accept    = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_on  <= 1'b0;
         lock_ctx <= '0;
      end else if (accept) begin
         lock_on <= cmd_more;
         if (cmd_more) lock_ctx <= cmd_ctx;
      end
   end
endmodule

// File: rtl/txsched_cmdq.sv
module txsched_cmdq
   import txsched_pkg::*;
#(
   parameter  int DEPTH = 4,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  txcmd_t        push_data,
   input  logic          pop,
   output txcmd_t        head,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   txcmd_t        mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;

   if (DEPTH < 2) begin : g_bad_depth
      $error("txsched_cmdq: DEPTH must be at least 2");
   end

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap
      assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head  = mem[rp];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/txsched_occ.sv
module txsched_occ
   import txsched_pkg::*;
#(
   parameter  int FIFO_DEPTH = 64,
   localparam int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [LEN_W-1:0] add_len,
   input  logic [OCC_W-1:0] drain,
   input  logic [OCC_W-1:0] thresh,
   output logic [OCC_W-1:0] occ,
   output logic [OCC_W-1:0] free_units,
   output logic             full,
   output logic             low
);
   logic [OCC_W-1:0] take, add;

   if (FIFO_DEPTH < 1 || OCC_W > LEN_W) begin : g_bad_depth
      $error("txsched_occ: FIFO_DEPTH out of range");
   end

   assign take       = (drain > occ) ? occ : drain;
   assign add        = add_en ? add_len[OCC_W-1:0] : '0;
   assign free_units = OCC_W'(FIFO_DEPTH) - occ;
   assign full       = (occ == OCC_W'(FIFO_DEPTH));
   assign low        = (occ < thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + add - take;
   end
endmodule

// File: rtl/txsched_ctxstat.sv
module txsched_ctxstat
   import txsched_pkg::*;
#(
   parameter  int QDEPTH = 4,
   localparam int PEND_W = $clog2(QDEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic [CTX_W-1:0] acc_ctx,
   input  logic             iss_en,
   input  logic [CTX_W-1:0] iss_ctx,
   input  logic [LEN_W-1:0] iss_len,
   input  logic             iss_more,
   input  logic [CTX_W-1:0] rd_ctx,
   output logic             rd_busy,
   output logic             rd_done,
   output logic [LEN_W-1:0] rd_len
);
   logic [NUM_CTX-1:0]            busy_v, done_v;
   logic [NUM_CTX-1:0][LEN_W-1:0] len_v;

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
      logic [PEND_W-1:0] pend;
      logic              done_q;
      logic [LEN_W-1:0]  len_q;
      logic              inc, dec;

      assign inc = acc_en && (acc_ctx == CTX_W'(g));
      assign dec = iss_en && (iss_ctx == CTX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend   <= '0;
            done_q <= 1'b0;
            len_q  <= '0;
         end else begin
            case ({inc, dec})
               2'b10:   pend <= pend + 1'b1;
               2'b01:   pend <= pend - 1'b1;
               default: pend <= pend;
            endcase
            if (dec) begin
               len_q  <= (done_q ? '0 : len_q) + iss_len;
               done_q <= !iss_more;
            end
         end
      end

      assign busy_v[g] = (pend != '0);
      assign done_v[g] = done_q;
      assign len_v[g]  = len_q;
   end

   assign rd_busy = busy_v[rd_ctx];
   assign rd_done = done_v[rd_ctx];
   assign rd_len  = len_v[rd_ctx];
endmodule

// File: rtl/txsched_top.sv
module txsched_top
   import txsched_pkg::*;
#(
   parameter  int QDEPTH     = 4,
   parameter  int FIFO_DEPTH = 64,
   parameter  int ADDR_W     = 20,
   localparam int OCC_W      = $clog2(FIFO_DEPTH + 1),
   localparam int QCW        = $clog2(QDEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg_word,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              cmd_more,
   output logic              issue_valid,
   input  logic              issue_ready,
   output logic [CTX_W-1:0]  issue_ctx,
   output logic [LEN_W-1:0]  issue_len,
   output logic              issue_more,
   input  logic [OCC_W-1:0]  drain_cnt,
   input  logic [OCC_W-1:0]  low_thresh,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       done_word
);
   if (ADDR_W < CTX_SHIFT + CTX_W) begin : g_bad_addr
      $error("txsched_top: ADDR_W too narrow for the interface index");
   end

   logic [CTX_W-1:0] cmd_ctx, rd_ctx, lock_ctx;
   logic             accept, lock_on, q_empty, q_full, issue_fire;
   logic             occ_full, occ_low, rd_busy, rd_done;
   logic [QCW-1:0]   q_count;
   logic [OCC_W-1:0] occ_q, free_units;
   logic [LEN_W-1:0] rd_len;
   txcmd_t           q_head, q_in;

   assign cmd_ctx = cmd_addr[CTX_SHIFT +: CTX_W];
   assign rd_ctx  = rd_addr[CTX_SHIFT +: CTX_W];
   assign q_in    = '{ctx: cmd_ctx, len: cmd_len, more: cmd_more};

   txsched_gate u_gate (
      .clk(clk), .rst_n(rst_n), .tx_en(cfg_word[CFG_TXEN]), .q_full(q_full),
      .cmd_valid(cmd_valid), .cmd_ctx(cmd_ctx), .cmd_more(cmd_more),
      .cmd_ready(cmd_ready), .accept(accept), .lock_on(lock_on), .lock_ctx(lock_ctx)
   );

   txsched_cmdq #(.DEPTH(QDEPTH)) u_cmdq (
      .clk(clk), .rst_n(rst_n), .push(accept), .push_data(q_in), .pop(issue_fire),
      .head(q_head), .empty(q_empty), .full(q_full), .count(q_count)
   );

   assign issue_valid = !q_empty && (q_head.len <= LEN_W'(free_units));
   assign issue_fire  = issue_valid && issue_ready;
   assign issue_ctx   = q_head.ctx;
   assign issue_len   = q_head.len;
   assign issue_more  = q_head.more;

   txsched_occ #(.FIFO_DEPTH(FIFO_DEPTH)) u_occ (
      .clk(clk), .rst_n(rst_n), .add_en(issue_fire), .add_len(q_head.len),
      .drain(drain_cnt), .thresh(low_thresh), .occ(occ_q), .free_units(free_units),
      .full(occ_full), .low(occ_low)
   );

   txsched_ctxstat #(.QDEPTH(QDEPTH)) u_stat (
      .clk(clk), .rst_n(rst_n), .acc_en(accept), .acc_ctx(cmd_ctx),
      .iss_en(issue_fire), .iss_ctx(q_head.ctx), .iss_len(q_head.len),
      .iss_more(q_head.more), .rd_ctx(rd_ctx),
      .rd_busy(rd_busy), .rd_done(rd_done), .rd_len(rd_len)
   );

   always_comb begin
      done_word          = '0;
      done_word[DW_BUSY] = rd_busy;
      done_word[DW_DONE] = rd_done;
      done_word[DW_FULL] = occ_full;
      done_word[DW_LOW]  = occ_low;
      done_word[LEN_W-1:0] = rd_len;
   end
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk
   import txsched_pkg::*;
#(
   parameter  int QDEPTH     = 4,
   parameter  int FIFO_DEPTH = 64,
   localparam int OCC_W      = $clog2(FIFO_DEPTH + 1),
   localparam int QCW        = $clog2(QDEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      cfg_word,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [CTX_W-1:0] cmd_ctx,
   input logic             lock_on,
   input logic [CTX_W-1:0] lock_ctx,
   input logic [QCW-1:0]   q_count,
   input logic [OCC_W-1:0] occ_q,
   input logic             issue_valid,
   input logic             issue_ready,
   input logic [CTX_W-1:0] issue_ctx,
   input logic [LEN_W-1:0] issue_len,
   input logic             issue_more,
   input logic [31:0]      done_word
);
   // R2
   no_push_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_word[CFG_TXEN] |=> q_count <= $past(q_count));

   // R4
   lock_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && lock_on) |-> cmd_ctx == lock_ctx);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= QCW'(QDEPTH));

   // R5
   full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count == QCW'(QDEPTH) |-> !cmd_ready);

   // R3
   issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready) |=> issue_valid && $stable(issue_ctx)
         && $stable(issue_len) && $stable(issue_more));

   // R7
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OCC_W'(FIFO_DEPTH));

   // R8
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_word[27:20] == 8'h00);
endmodule

bind txsched_top txsched_chk #(.QDEPTH(QDEPTH), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready), .cmd_ctx(cmd_ctx), .lock_on(lock_on), .lock_ctx(lock_ctx),
   .q_count(q_count), .occ_q(occ_q), .issue_valid(issue_valid),
   .issue_ready(issue_ready), .issue_ctx(issue_ctx), .issue_len(issue_len),
   .issue_more(issue_more), .done_word(done_word)
);

// File: tb/txsched_tb.sv
module txsched_top_tb_top;
   localparam int QD = 4;
   localparam int FD = 64;
   localparam int AW = 20;
   localparam int OW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   cfg_word = 32'h0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [AW-1:0] cmd_addr = '0;
   logic [19:0]   cmd_len = '0;
   logic          cmd_more = 1'b0;
   logic          issue_valid, issue_more;
   logic          issue_ready = 1'b0;
   logic [7:0]    issue_ctx;
   logic [19:0]   issue_len;
   logic [OW-1:0] drain_cnt = '0;
   logic [OW-1:0] low_thresh = 7'd16;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   done_word;

   always #10 clk = ~clk;

   txsched_top #(.QDEPTH(QD), .FIFO_DEPTH(FD), .ADDR_W(AW)) dut_i (.*);

   int checks = 0, fails = 0;
   int qc[$], ql[$];
   bit qm[$];
   int pend[256], cla[256];
   bit cmpa[256];
   bit lk = 0;
   int lkctx = 0, occ = 0;
   bit e_ready, e_iv;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic int actx(input logic [AW-1:0] a);
      return int'(a[15:8]);
   endfunction

   task automatic cyc();
      int c, r;
      logic [31:0] ew;
      #2;
      c = actx(cmd_addr);
      e_ready = cfg_word[1] && (qc.size() < QD) && (!lk || c == lkctx);
      chk(!cfg_word[1] ? "R2" : (qc.size() >= QD ? "R5" : "R4"), "cmd_ready",
          32'(cmd_ready), 32'(e_ready));
      e_iv = (qc.size() > 0) && (ql[0] <= FD - occ);
      chk(qc.size() > 0 ? "R6" : "R3", "issue_valid", 32'(issue_valid), 32'(e_iv));
      if (e_iv) begin
         chk("R3", "issue_ctx", 32'(issue_ctx), 32'(qc[0]));
         chk("R3", "issue_len", 32'(issue_len), 32'(ql[0]));
         chk("R3", "issue_more", 32'(issue_more), 32'(qm[0]));
      end
      r = actx(rd_addr);
      ew = {pend[r] != 0, cmpa[r], occ == FD, occ < int'(low_thresh), 8'h00, 20'(cla[r])};
      chk("R7", "done_flags", {2'b0, done_word[29:28], 28'h0}, {2'b0, ew[29:28], 28'h0});
      chk("R8", "done_busy", {done_word[31], done_word[27:20]}, {ew[31], ew[27:20]});
      chk("R9", "done_len", {done_word[30], done_word[19:0]}, {ew[30], ew[19:0]});
      @(posedge clk);
      begin
         int inc = 0, dr;
         if (e_iv && issue_ready) begin
            int ec = qc.pop_front();
            int el = ql.pop_front();
            bit em = qm.pop_front();
            pend[ec]--;
            cla[ec] = ((cmpa[ec] ? 0 : cla[ec]) + el) & 32'hFFFFF;
            cmpa[ec] = !em;
            inc = el;
         end
         dr = (int'(drain_cnt) > occ) ? occ : int'(drain_cnt);
         occ = occ + inc - dr;
         if (cmd_valid && e_ready) begin
            qc.push_back(c); ql.push_back(int'(cmd_len)); qm.push_back(cmd_more);
            pend[c]++;
            if (cmd_more) begin lk = 1; lkctx = c; end
            else lk = 0;
         end
      end
      @(negedge clk);
   endtask

   task automatic post(input int c, input int len, input bit more);
      cmd_valid = 1'b1;
      cmd_addr  = AW'({4'($urandom), 8'(c), 8'($urandom)});
      cmd_len   = 20'(len);
      cmd_more  = more;
      cyc();
      cmd_valid = 1'b0;
   endtask

   task automatic rd(input int c);
      rd_addr = AW'({4'($urandom), 8'(c), 8'($urandom)});
   endtask

   initial begin
      foreach (pend[i]) begin pend[i] = 0; cla[i] = 0; cmpa[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cfg_word = 32'h2;
      #2;
      // R10: reset state at the ports
      chk("R10", "ready_after_reset", 32'(cmd_ready), 32'd1);
      chk("R10", "issue_valid_after_reset", 32'(issue_valid), 32'd0);
      chk("R10", "done_after_reset", done_word, 32'h1000_0000);
      @(negedge clk);

      // R2: transmit enable clear, other config bits set
      cfg_word = 32'hFFFF_FFFD;
      for (int i = 0; i < 4; i++) post(3, 5, 0);
      rd(3);
      cyc();
      chk("R2", "no_busy_when_disabled", 32'(done_word[31]), 32'd0);
      cfg_word = 32'h2;

      // R5: fill the queue with the engine stalled
      issue_ready = 1'b0;
      post(3, 30, 0); post(7, 30, 0); post(3, 30, 0); post(9, 20, 0);
      post(11, 1, 0);
      chk("R5", "ready_low_when_full", 32'(cmd_ready), 32'd0);
      rd(3);
      cyc();
      // R6: engine takes two, third waits for room
      issue_ready = 1'b1;
      repeat (4) cyc();
      chk("R6", "blocked_by_space", 32'(issue_valid), 32'd0);
      // R7: clamped drain larger than occupancy
      drain_cnt = 7'd64;
      cyc();
      drain_cnt = 7'd0;
      repeat (3) cyc();
      drain_cnt = 7'd64;
      repeat (3) cyc();

      // R4/R9: locked packet built from three pieces
      post(5, 4, 1);
      post(6, 7, 0);
      chk("R4", "other_ctx_refused", 32'(cmd_ready), 32'd0);
      post(5, 3, 1);
      post(6, 7, 0);
      post(5, 2, 0);
      post(6, 7, 0);
      rd(5);
      repeat (4) cyc();
      chk("R9", "packet_len", 32'(done_word[19:0]), 32'd9);
      chk("R9", "packet_complete", 32'(done_word[30]), 32'd1);
      begin
         logic [31:0] w1;
         w1 = done_word;
         rd_addr = AW'({4'hA, 8'd5, 8'h3C});
         #1;
         // R1: bits outside [15:8] ignored on the read address
         chk("R1", "rd_addr_other_bits", done_word, w1);
      end

      // random traffic over a few interfaces
      for (int n = 0; n < 2500; n++) begin
         int pick[4] = '{1, 2, 3, 200};
         int c = pick[$urandom % 4];
         cmd_valid   = ($urandom % 3) != 0;
         cmd_addr    = AW'({4'($urandom), 8'(c), 8'($urandom)});
         cmd_len     = 20'(1 + $urandom % 12);
         cmd_more    = ($urandom % 10) < 3;
         issue_ready = ($urandom % 4) != 0;
         drain_cnt   = OW'($urandom % 7);
         low_thresh  = OW'(8 + $urandom % 24);
         rd(pick[$urandom % 4]);
         cyc();
      end
      cmd_valid = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule